// File: doc/BRIEF.md
# Packed-Register Interrupt Concentrator

This block gathers a small group of edge-signalled interrupt sources into one level interrupt for a parent controller. Software sees a single 32-bit word. The low half holds one mask (enable) bit per source. The high half holds one pending (status) bit per source, and each pending bit sits exactly 16 positions above its mask bit.

A rising edge on a source input sets that source's pending bit, whatever the mask says. Software clears a pending bit by writing a one to it. A zero written to a pending bit has no effect. Because of this, a read-modify-write that changes only the masks, and writes zeros to the pending field, leaves pending events alone. The parent output is a registered OR of every pending bit that is also unmasked.

The parameter `NUM_SRC` sets the number of sources and `BASE_BIT` sets the first mask position. For example, 7 sources at bit 0, 6 sources at bit 0, or 2 sources at bit 4. Register bits outside the configured fields read as zero. Writes to them are discarded.

Top module: `irq_word_agg`

## Requirements
- R1: After reset, every mask bit and every pending bit is 0, and `irq_o` is 0.
- R2: When `src_i[k]` is 1 in a cycle and was 0 in the previous cycle (the sampled history is 0 after reset), pending bit `16+BASE_BIT+k` is set at that clock edge, whatever the state of the mask. A source that stays high does not set the bit again.
- R3: A write with bit `16+BASE_BIT+k` of `wr_data` at 1 clears pending bit k. A write with that bit at 0 leaves pending bit k unchanged.
- R4: A write loads mask bit k from bit `BASE_BIT+k` of `wr_data`.
- R5: If a rising edge on source k and a clearing write to pending bit k happen in the same cycle, the pending bit ends up set.
- R6: `irq_o` in a cycle equals the OR over k of (pending k AND mask k) as held in the register during the previous cycle. This gives one cycle of latency after the register state changes.
- R7: `rd_data` bits outside `[BASE_BIT +: NUM_SRC]` and `[16+BASE_BIT +: NUM_SRC]` always read 0, including after writes of all ones.
- R8: A pending bit whose mask is 0 does not raise `irq_o`. Setting the mask later, while the bit is still pending, raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Interrupt source levels, edge-detected |
| wr_en | input | 1 | Write strobe for the packed register |
| wr_data | input | 32 | Write data: masks low, write-one-to-clear pending high |
| rd_data | output | 32 | Current packed register contents |
| irq_o | output | 1 | Registered level interrupt to the parent |

## Verification
The hardest case to reach is a clearing write that lands on the very clock edge where the same source rises. The bench drives both at the same falling edge, so they meet at one rising edge, and then checks that the pending bit survives. A second hard case is unmasking a source whose pending bit is already set. The bench reaches it with a mask-only write that carries zeros in the pending field, and confirms that the event is still pending and that the interrupt rises one cycle later. A behavioural model, compared on every clock, also follows a long pseudo-random mix of source toggles and writes.

// File: rtl/irqw_pkg.sv
package irqw_pkg;
  localparam int REG_W  = 32;
  localparam int STAT_SHIFT = 16;
endpackage

// File: rtl/irqw_edge.sv
module irqw_edge #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~hist_q;
endmodule

// File: rtl/irqw_bank.sv
module irqw_bank #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise_i,
  input  logic         wr_en,
  input  logic [W-1:0] wr_mask,
  input  logic [W-1:0] wr_clr,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] pend_q
);
  logic [W-1:0] clr_eff;
  assign clr_eff = wr_en ? wr_clr : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (wr_en) mask_q <= wr_mask;
      pend_q <= (pend_q & ~clr_eff) | rise_i;
    end
  end

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_i) |=> ((pend_q & $past(rise_i)) == $past(rise_i)));

  // R3
  clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ((wr_clr & ~rise_i) != '0)) |=> ((pend_q & $past(wr_clr & ~rise_i)) == '0));

  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mask_q == $past(wr_mask)));
endmodule

// File: rtl/irqw_out.sv
module irqw_out #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] pend_i,
  output logic         irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(mask_i & pend_i);
  end
endmodule

// File: rtl/irq_word_agg.sv
module irq_word_agg #(
  parameter int NUM_SRC  = 7,
  parameter int BASE_BIT = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  output logic               irq_o
);
  import irqw_pkg::*;

  localparam int PEND_LO = STAT_SHIFT + BASE_BIT;

  initial begin
    if (NUM_SRC < 1 || NUM_SRC + BASE_BIT > STAT_SHIFT)
      $error("irq_word_agg: field does not fit in the low half");
  end

  logic [NUM_SRC-1:0] rise, mask_q, pend_q;

  irqw_edge #(.W(NUM_SRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(src_i), .rise_o(rise)
  );

  irqw_bank #(.W(NUM_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .wr_en(wr_en),
    .wr_mask(wr_data[BASE_BIT +: NUM_SRC]),
    .wr_clr(wr_data[PEND_LO +: NUM_SRC]),
    .mask_q(mask_q), .pend_q(pend_q)
  );

  irqw_out #(.W(NUM_SRC)) u_out (
    .clk(clk), .rst_n(rst_n), .mask_i(mask_q), .pend_i(pend_q), .irq_o(irq_o)
  );

  always_comb begin
    rd_data = '0;
    rd_data[BASE_BIT +: NUM_SRC] = mask_q;
    rd_data[PEND_LO +: NUM_SRC]  = pend_q;
  end

  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(rd_data[BASE_BIT +: NUM_SRC] & rd_data[PEND_LO +: NUM_SRC]))));

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[BASE_BIT +: NUM_SRC] == '0) |=> !irq_o);
endmodule

// File: tb/irq_word_agg_test.sv
module irq_word_agg_test;
  localparam int N = 7;
  localparam int B = 0;
  localparam int PL = 16 + B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic wr = 1'b0;
  logic [31:0] wdat = '0;
  logic [31:0] rdat;
  logic irq;

  irq_word_agg #(.NUM_SRC(N), .BASE_BIT(B)) uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr),
    .wr_data(wdat), .rd_data(rdat), .irq_o(irq)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;
  string phase = "R1";

  bit [N-1:0] m_en, m_st, m_prev;
  bit m_irq;

  function automatic logic [31:0] model_word();
    logic [31:0] w;
    w = '0;
    w[B +: N] = m_en;
    w[PL +: N] = m_st;
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // one clock: drive at negedge, model steps at posedge, compare after
  task automatic step(input logic [N-1:0] s, input logic w, input logic [31:0] d);
    bit [N-1:0] rise, nst;
    @(negedge clk);
    src = s; wr = w; wdat = d;
    @(posedge clk);
    rise = s & ~m_prev;
    m_prev = s;
    nst = (m_st & ~(w ? d[PL +: N] : '0)) | rise;
    m_irq = |(m_st & m_en);
    if (w) m_en = d[B +: N];
    m_st = nst;
    #1;
    check({phase, " word"}, rdat, model_word());
    check({phase, " irq"}, {31'b0, irq}, {31'b0, m_irq});
  endtask

  function automatic logic [31:0] mk(input logic [N-1:0] en, input logic [N-1:0] clr);
    logic [31:0] w;
    w = '0;
    w[B +: N] = en;
    w[PL +: N] = clr;
    return w;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    logic [15:0] lfsr;
    m_en = '0; m_st = '0; m_prev = '0; m_irq = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 word in reset", rdat, 32'h0);
    check("R1 irq in reset", {31'b0, irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    step('0, 0, '0);

    // R2/R8: edge while masked sets status, no irq
    phase = "R2";
    step(7'b0000100, 0, '0);
    step(7'b0000100, 0, '0);
    check("R2 pending bit set", {31'b0, rdat[PL+2]}, 32'h1);
    phase = "R8";
    step('0, 0, '0);
    check("R8 masked no irq", {31'b0, irq}, 32'h0);

    // R4/R8: unmask with zeros in status field keeps pending
    phase = "R4";
    step('0, 1, mk(7'b0000100, '0));
    check("R4 mask loaded", {31'b0, rdat[B+2]}, 32'h1);
    check("R8 pending preserved", {31'b0, rdat[PL+2]}, 32'h1);
    phase = "R6";
    step('0, 0, '0);
    check("R6 irq one cycle later", {31'b0, irq}, 32'h1);

    // R3: write-one clear
    phase = "R3";
    step('0, 1, mk(7'b0000100, 7'b0000100));
    check("R3 cleared", {31'b0, rdat[PL+2]}, 32'h0);
    step('0, 0, '0);

    // R2: held level does not re-set
    phase = "R2";
    step(7'b0000010, 0, '0);
    step(7'b0000010, 1, mk(7'b0000100, 7'b0000010));
    step(7'b0000010, 0, '0);
    step(7'b0000010, 0, '0);
    check("R2 held high no re-set", {31'b0, rdat[PL+1]}, 32'h0);

    // R5: edge and clear on same cycle
    phase = "R5";
    step(7'b0001010, 1, mk(7'b0001000, 7'b0001000));
    check("R5 set wins over clear", {31'b0, rdat[PL+3]}, 32'h1);
    step(7'b0001010, 0, '0);

    // R7: write all ones
    phase = "R7";
    step('0, 1, 32'hFFFF_FFFF);
    check("R7 outside bits zero", rdat & ~mk('1, '1), 32'h0);
    step('0, 0, '0);

    // R6: pseudo-random mix
    phase = "R6";
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[N-1:0], (lfsr[9:8] == 2'b11), {lfsr, lfsr[7:0], lfsr[15:8]});
    end

    finish_run();
  end
endmodule